// File: doc/BRIEF.md
# Programmable Interval Timer with Reload

The block is a 16-bit down-counting periodic interrupt timer. Its count steps once every 2^(P+1) clock cycles, where P is a 4-bit prescale field, giving step periods from 2 to 65536 clocks. When the count reaches zero, the next step raises a sticky expiry flag and loads the count again. With reload selected, the value loaded is the modulus register. Otherwise the count wraps to 0xFFFF.

Software reaches the block through a simple synchronous port. This port holds a control register, a modulus register and a read-only count. The expiry flag is cleared by writing one to it. An interrupt-enable bit gates the flag onto the interrupt line. Writing the modulus has side effects: it always clears the flag, and it can overwrite the running count at once. A control write that changes only the interrupt bits leaves the count and the prescaler running. Any other control change reconfigures the timer and restarts it.

Top module: `pit_timer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all three registers read zero, the count is stopped and irq_o is low.
- R2: Register offsets on `addr` are 0 for control, 2 for modulus and 4 for count.
  - Control bit fields: bit 0 is run enable, bit 1 is reload select, bit 2 is the expiry flag, bit 3 is interrupt enable, bit 4 is overwrite and bits 11:8 are the prescale P.
  - The other control bits are stored and read back, but have no effect.
  - Writes to offset 4 or to any other offset change nothing, and reads from other offsets return 0.
- R3: While enabled, the count steps once every 2^(P+1) clock cycles. After a restart, the first step comes 2^(P+1) cycles later.
- R4: On each step the count decrements by one. On a step taken at count 0, the count loads its reload value and the expiry flag is set. The reload value is the modulus when reload select is 1, and 0xFFFF otherwise.
- R5: Writing 1 to control bit 2 clears the flag. Writing 0 to it leaves the flag unchanged. No write can set the flag.
- R6: irq_o is high exactly when the flag and interrupt enable are both set, and it follows them in the same cycle.
- R7: A control write whose value differs from the stored control only in bits 2 and 3 leaves the count and the prescaler undisturbed.
- R8: Any other control write clears the prescaler and loads the count with the reload value chosen by the newly written reload bit. Counting then runs only if the new enable bit is 1.
- R9: A modulus write always clears the flag. If overwrite is already set in the control register, the written value is also loaded into the count at once.
- R10: Without overwrite, a modulus write leaves the count alone, and the new modulus is first used at the next reload.
- R11: Collisions within one cycle:
  - An expiry wins over a same-cycle flag clear.
  - A count load caused by a write (restart or overwrite) wins over a same-cycle step. That step is dropped and sets no flag.
- R12: While enable is 0, the count and the prescaler hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, taken at the rising edge |
| addr | input | 3 | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
Every effect of a write, and every count step, becomes visible on rdata and irq_o after the rising edge that takes it. No extra pipeline stage delays it. The bench drives one stimulus per cycle on the falling edge. After the next rising edge, it advances its own register model by one cycle. It then reads all offsets at the following falling edge, so every comparison lands in the exact cycle the result is due. The directed part places a flag clear on the very edge of an expiry, and times prescale periods, reloads and modulus side effects cycle by cycle. The random part mixes control, modulus, minor and ignored writes with idle cycles.

// File: rtl/pit_pkg.sv
// Shared field positions and register offsets of the interval timer.
package pit_pkg;
    localparam int CTL_EN     = 0;
    localparam int CTL_RLD    = 1;
    localparam int CTL_FLAG   = 2;
    localparam int CTL_IE     = 3;
    localparam int CTL_OVW    = 4;
    localparam int CTL_PRE_LO = 8;
    localparam int PRE_W      = 4;
    localparam int ADDR_W     = 3;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_MOD  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 3'd4;
endpackage

// File: rtl/pit_regs.sv
// Control, modulus and flag registers of the interval timer.
// Decodes writes into restart and overwrite-load requests for the counter.
// Assumes one access per cycle; the flag bit is never stored in ctrl_q.
module pit_regs #(
    parameter int DATA_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [pit_pkg::ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       expire,
    output logic [DATA_W-1:0]          ctrl_q,
    output logic [DATA_W-1:0]          mod_q,
    output logic                       flag_q,
    output logic                       restart,
    output logic                       load_en,
    output logic [DATA_W-1:0]          load_val,
    output logic [DATA_W-1:0]          reload_val
);
    import pit_pkg::*;

    localparam logic [DATA_W-1:0] FLAG_MASK  = DATA_W'(1) << CTL_FLAG;
    localparam logic [DATA_W-1:0] MINOR_MASK = FLAG_MASK | (DATA_W'(1) << CTL_IE);

    logic ctrl_wr, mod_wr, ovw_load;

    // Decode the write strobes and the requests they raise.
    always_comb begin
        ctrl_wr  = wr_en && (addr == OFS_CTRL);
        mod_wr   = wr_en && (addr == OFS_MOD);
        restart  = ctrl_wr && (((ctrl_q ^ wdata) & ~MINOR_MASK) != '0);
        ovw_load = mod_wr && ctrl_q[CTL_OVW];
        load_en  = restart || ovw_load;
    end

    // Select the values the counter loads on a request or on expiry.
    always_comb begin
        reload_val = ctrl_q[CTL_RLD] ? mod_q : '1;
        if (restart)
            load_val = wdata[CTL_RLD] ? mod_q : '1;
        else
            load_val = wdata;
    end

    // Store control and modulus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mod_q  <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= wdata & ~FLAG_MASK;
            if (mod_wr)  mod_q  <= wdata;
        end
    end

    // Sticky expiry flag; expiry outranks any same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (expire)
            flag_q <= 1'b1;
        else if (mod_wr || (ctrl_wr && wdata[CTL_FLAG]))
            flag_q <= 1'b0;
    end
endmodule

// File: rtl/pit_prescaler.sv
// Power-of-two prescaler: tick pulses once every 2^(pre+1) cycles while run is high.
// Assumes clear restarts the period from zero; holds at zero while stopped.
module pit_prescaler #(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [PRE_W-1:0] pre,
    output logic             tick
);
    localparam int PCNT_W = (1 << PRE_W);

    logic [PCNT_W-1:0] pcnt_q;
    logic [PCNT_W:0]   terminal;

    // Last count value of the selected period.
    always_comb begin
        terminal = ((PCNT_W+1)'(1) << (32'(pre) + 1)) - 1'b1;
        tick     = run && ({1'b0, pcnt_q} == terminal);
    end

    // Advance the division count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !run)
            pcnt_q <= '0;
        else if (tick)
            pcnt_q <= '0;
        else
            pcnt_q <= pcnt_q + 1'b1;
    end
endmodule

// File: rtl/pit_counter.sv
// Down counter of the interval timer: decrements on tick and reloads when a tick
// finds it at zero. A write-driven load outranks the tick, which is then dropped.
module pit_counter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] reload_val,
    output logic [DATA_W-1:0] cnt_q,
    output logic              expire
);
    // Expiry: a step that is not overridden, taken at zero.
    always_comb expire = tick && !load_en && (cnt_q == '0);

    // Update the count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_en)
            cnt_q <= load_val;
        else if (tick)
            cnt_q <= (cnt_q == '0) ? reload_val : cnt_q - 1'b1;
    end
endmodule

// File: rtl/pit_timer.sv
// Top of the programmable interval timer: register port, prescaler, counter
// and interrupt gating. Reads are combinational; writes take effect at the edge.
module pit_timer #(
    parameter int DATA_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [pit_pkg::ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic                       irq_o
);
    import pit_pkg::*;

    logic [DATA_W-1:0] ctrl_q, mod_q, cnt_q, load_val, reload_val;
    logic              flag_q, restart, load_en, tick, expire;

    pit_regs #(.DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .expire(expire), .ctrl_q(ctrl_q), .mod_q(mod_q), .flag_q(flag_q),
        .restart(restart), .load_en(load_en), .load_val(load_val),
        .reload_val(reload_val)
    );

    pit_prescaler #(.PRE_W(PRE_W)) presc_i (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q[CTL_EN]), .clear(restart),
        .pre(ctrl_q[CTL_PRE_LO +: PRE_W]), .tick(tick)
    );

    pit_counter #(.DATA_W(DATA_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load_en(load_en),
        .load_val(load_val), .reload_val(reload_val), .cnt_q(cnt_q),
        .expire(expire)
    );

    // Read multiplexer; the flag is merged into the control view.
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CTRL: begin
                rdata           = ctrl_q;
                rdata[CTL_FLAG] = flag_q;
            end
            OFS_MOD: rdata = mod_q;
            OFS_CNT: rdata = cnt_q;
            default: rdata = '0;
        endcase
    end

    // Interrupt gating.
    always_comb irq_o = flag_q && ctrl_q[CTL_IE];
endmodule

// File: rtl/pit_timer_chk.sv
// Assertion checker for pit_timer, attached through bind below.
module pit_timer_chk #(
    parameter int DATA_W = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [pit_pkg::ADDR_W-1:0] addr,
    input logic [DATA_W-1:0]          wdata,
    input logic [DATA_W-1:0]          rdata,
    input logic                       irq_o,
    input logic [DATA_W-1:0]          ctrl_q,
    input logic [DATA_W-1:0]          mod_q,
    input logic [DATA_W-1:0]          cnt_q,
    input logic                       flag_q,
    input logic                       tick,
    input logic                       load_en,
    input logic                       expire
);
    import pit_pkg::*;

    localparam logic [DATA_W-1:0] KEEP_MASK = ~((DATA_W'(1) << CTL_FLAG) | (DATA_W'(1) << CTL_IE));

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && cnt_q == '0 && !flag_q));

    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFS_CTRL) |-> (irq_o == (rdata[CTL_FLAG] && rdata[CTL_IE])));

    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CTRL && wdata[CTL_FLAG] && !expire) |=> !flag_q);

    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_en && ((addr == OFS_CTRL && wdata[CTL_FLAG]) || addr == OFS_MOD)))
        |=> flag_q);

    p_mod_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_MOD && !expire) |=> !flag_q);

    p_overwrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_MOD && ctrl_q[CTL_OVW]) |=> (cnt_q == $past(wdata)));

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (flag_q && (cnt_q == ($past(ctrl_q[CTL_RLD]) ? $past(mod_q) : '1))));

    p_minor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CTRL && ((wdata ^ ctrl_q) & KEEP_MASK) == '0 && !tick)
        |=> $stable(cnt_q));

    p_cnt_ro_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CNT && !tick) |=> $stable(cnt_q));

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[CTL_EN] && !load_en) |=> $stable(cnt_q));
endmodule

bind pit_timer pit_timer_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_o(irq_o), .ctrl_q(ctrl_q), .mod_q(mod_q),
    .cnt_q(cnt_q), .flag_q(flag_q), .tick(tick), .load_en(load_en),
    .expire(expire)
);

// File: tb/pit_timer_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases, then seeded random traffic,
// all compared against a cycle model built from the requirements.
module pit_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        irq_o;

    int n_tests = 0;
    int n_fail  = 0;

    // Model state
    logic [15:0] m_ctrl, m_mod, m_cnt;
    logic        m_flag;
    int          m_pre;

    always #2 clk = ~clk;

    pit_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] reload_of(input logic rld);
        return rld ? m_mod : 16'hFFFF;
    endfunction

    // One clock of the reference model, from the state before the edge.
    task automatic model_step(input bit we, input logic [2:0] a, input logic [15:0] d);
        int  divm1 = (1 << (int'(m_ctrl[11:8]) + 1)) - 1;
        bit  tk = m_ctrl[0] && (m_pre == divm1);
        bit  cw = we && (a == 3'd0);
        bit  mw = we && (a == 3'd2);
        bit  rs = cw && (((m_ctrl ^ d) & 16'hFFF3) != 16'h0);
        bit  ld = mw && m_ctrl[4];
        bit  ex = tk && !rs && !ld && (m_cnt == 16'h0);
        logic [15:0] ncnt = m_cnt;
        if (rs) ncnt = reload_of(d[1]);
        else if (ld) ncnt = d;
        else if (tk) ncnt = (m_cnt == 16'h0) ? reload_of(m_ctrl[1]) : m_cnt - 16'h1;
        if (rs || !m_ctrl[0] || tk) m_pre = 0;
        else m_pre = m_pre + 1;
        if (ex) m_flag = 1'b1;
        else if (mw || (cw && d[2])) m_flag = 1'b0;
        m_cnt = ncnt;
        if (cw) m_ctrl = d & 16'hFFFB;
        if (mw) m_mod = d;
    endtask

    // Drive one cycle, advance the model, then read every offset back.
    task automatic step(input bit we, input logic [2:0] a, input logic [15:0] d,
                        input string tag);
        wr_en = we; addr = a; wdata = d;
        @(posedge clk);
        model_step(we, a, d);
        @(negedge clk);
        wr_en = 1'b0;
        addr = 3'd0; #0.2 chk(tag, "ctrl", rdata, m_ctrl | (16'(m_flag) << 2));
        chk(tag, "irq", 16'(irq_o), 16'(m_flag && m_ctrl[3]));
        addr = 3'd2; #0.2 chk(tag, "mod", rdata, m_mod);
        addr = 3'd4; #0.2 chk(tag, "count", rdata, m_cnt);
        addr = 3'd6; #0.2 chk(tag, "unused", rdata, 16'h0);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, 16'h0, tag);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        logic [15:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_ctrl = 16'h0; m_mod = 16'h0; m_cnt = 16'h0; m_flag = 1'b0; m_pre = 0;
        addr = 3'd0; #0.2 chk("R1", "ctrl", rdata, 16'h0);
        chk("R1", "irq", 16'(irq_o), 16'h0);
        addr = 3'd2; #0.2 chk("R1", "mod", rdata, 16'h0);
        addr = 3'd4; #0.2 chk("R1", "count", rdata, 16'h0);
        addr = 3'd0;

        // R2: writes to count and unused offsets are ignored
        step(1'b1, 3'd4, 16'h1234, "R2");
        step(1'b1, 3'd6, 16'hBEEF, "R2");
        // R10: modulus without overwrite leaves the count
        step(1'b1, 3'd2, 16'd5, "R10");
        // R8: restart with enable, reload, irq enable, stored side bits, P=1
        step(1'b1, 3'd0, 16'h016B, "R8");
        chk("R8", "count after restart", m_cnt, 16'd5);
        // R3/R4/R6: run through an expiry
        idle(3, "R3");
        idle(1, "R3");
        chk("R3", "first step", m_cnt, 16'd4);
        idle(22, "R4");
        chk("R6", "irq after expiry", 16'(irq_o), 16'h1);
        // R7: minor write clears flag and drops ie, count undisturbed
        step(1'b1, 3'd0, 16'h0167, "R7");
        idle(5, "R7");
        // R5: writing 0 to the flag leaves it; flag cannot be set by software
        step(1'b1, 3'd0, 16'h016B, "R5");
        idle(25, "R5");
        step(1'b1, 3'd0, 16'h0163, "R5");
        // R10: new modulus used at next reload
        step(1'b1, 3'd2, 16'd9, "R10");
        idle(40, "R10");
        // R9: overwrite loads immediately and clears flag
        step(1'b1, 3'd0, 16'h017B, "R9");
        step(1'b1, 3'd2, 16'd2, "R9");
        chk("R9", "count after overwrite", m_cnt, 16'd2);
        idle(12, "R9");
        // R12: disabled timer holds
        step(1'b1, 3'd0, 16'h0172, "R12");
        idle(10, "R12");
        // R11: flag clear on the very edge of an expiry
        step(1'b1, 3'd0, 16'h0000, "R11");
        step(1'b1, 3'd2, 16'h0000, "R11");
        step(1'b1, 3'd0, 16'h000B, "R11");
        step(1'b0, 3'd0, 16'h0000, "R11");
        step(1'b1, 3'd0, 16'h000F, "R11");
        chk("R11", "flag kept", 16'(irq_o), 16'h1);
        // R11: overwrite collides with a step
        step(1'b1, 3'd0, 16'h001B, "R11");
        step(1'b0, 3'd0, 16'h0000, "R11");
        step(1'b1, 3'd2, 16'h0007, "R11");

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom % 16;
            d = 16'($urandom);
            if (r < 2) begin
                d[11:8] = 4'($urandom % 3);
                d[0] = ($urandom % 4) != 0;
                step(1'b1, 3'd0, d, "R8");
            end else if (r == 2) begin
                step(1'b1, 3'd2, 16'($urandom % 40), "R9");
            end else if (r == 3) begin
                step(1'b1, ($urandom % 2) ? 3'd4 : 3'd6, d, "R2");
            end else if (r == 4) begin
                d = m_ctrl;
                d[2] = $urandom % 2;
                d[3] = $urandom % 2;
                step(1'b1, 3'd0, d, "R7");
            end else begin
                step(1'b0, 3'd0, 16'h0, "R4");
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule